// File: doc/BRIEF.md
# Processor Memory Request Generator

This block builds the memory request for one processor. Its control logic raises `acc_valid` with an access kind and the operands it has on hand. The block then emits, one cycle later, a registered request made of a 3-bit type code, an (x, y) index pair and an identifier. The operand that lands in each index depends on the kind. Instruction fetches are indexed by the program counter, constant reads by the constant index, and input reads by the coordinates and identifier taken from the instruction. Output writes always use the processor's assigned work pair.

Output writes can be gated by an external test unit. With gating on, the block does not issue the write at once. It latches the work pair, the output identifier and the chosen conditional value, and presents them to the test unit. It then holds, with `acc_ready` low, until the test unit answers. A passing answer releases the write. A failing answer drops it and raises `discard` for one cycle. The conditional value is either an immediate from the instruction or the value that came with the work pair, as `cond_sel` picks. With gating off, writes go out as if the test always passes.

Top module: `mem_req_gen`

## Requirements
- R1: After reset `req_valid`, `discard` and `test_req_valid` are low and `acc_ready` is high.
- R2: An accepted access of kind 0 (instruction fetch) produces, on the next cycle, a request with `req_type`=0, `req_x`=`pc`, `req_y`=0 and `req_id`=0.
- R3: An accepted access of kind 1, 2 or 3 (float, integer, boolean constant) produces, on the next cycle, a request with `req_type` equal to the kind, `req_x`=`op_idx`, `req_y`=0 and `req_id`=0.
- R4: An accepted access of kind 4 (input read) produces, on the next cycle, a request with `req_type`=4, `req_x`=`in_x`, `req_y`=`in_y` and `req_id`=`in_id`.
- R5: With `cond_en` low, an accepted access of kind 5 (output write) produces, on the next cycle, a request with `req_type`=5, `req_x`=`work_i`, `req_y`=`work_j` and `req_id`=`out_id`, and no test request.
- R6: With `cond_en` high, an accepted kind-5 access produces no request on the next cycle. From that cycle `test_req_valid` is high and `acc_ready` is low, with `test_i`/`test_j` holding the captured work pair, until the cycle after `test_done` is sampled high.
- R7: The captured `test_val` equals `imm_cond` when `cond_sel` is 1 and `work_cond` when `cond_sel` is 0.
- R8: When `test_done` is sampled high with `test_pass` high, the next cycle carries a kind-5 request built from the captured pair and identifier.
- R9: When `test_done` is sampled high with `test_pass` low, no request is issued and `discard` is high for exactly that next cycle.
- R10: An access with kind 6 or 7 produces neither a request nor a test request.
- R11: While a test is pending, `acc_valid` is ignored. No request comes from it, and the captured test fields stay unchanged.
- R12: `req_valid` is high for exactly one cycle per issued request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request from processor control |
| acc_kind | input | 3 | Access kind, 0..5 legal |
| pc | input | XW | Program counter |
| op_idx | input | XW | Constant index from instruction |
| in_x | input | XW | Input x index from instruction |
| in_y | input | YW | Input y index from instruction |
| in_id | input | IDW | Input identifier from instruction |
| out_id | input | IDW | Output identifier from instruction |
| work_i | input | XW | Assigned work pair, i |
| work_j | input | YW | Assigned work pair, j |
| work_cond | input | CW | Conditional value delivered with the work pair |
| imm_cond | input | CW | Immediate conditional value from instruction |
| cond_sel | input | 1 | 1 selects immediate, 0 selects work value |
| cond_en | input | 1 | Enables conditional gating of output writes |
| acc_ready | output | 1 | Low while a test is pending |
| req_valid | output | 1 | Request strobe to memory controller |
| req_type | output | 3 | Request type code |
| req_x | output | XW | Request x index |
| req_y | output | YW | Request y index |
| req_id | output | IDW | Request identifier |
| test_req_valid | output | 1 | Test request to conditional unit |
| test_val | output | CW | Conditional value under test |
| test_i | output | XW | Work pair i under test |
| test_j | output | YW | Work pair j under test |
| test_done | input | 1 | Test result valid |
| test_pass | input | 1 | Test result |
| discard | output | 1 | One-cycle pulse when a gated write is dropped |

## Verification
The bench aims at the index multiplexing: a design that routed `op_idx` into fetches, or left a stale y on constants, shows wrong indices on random operands. It varies the test latency and pushes stray accesses into the pending window. A design that let them through would issue an extra request or overwrite the captured pair, so the released write would carry the wrong coordinates. It checks both answers of the test. A design that inverted or delayed the verdict would show a write where `discard` belongs. Codes 6 and 7 are driven to catch a decoder that leaks them as requests.

// File: rtl/mem_req_gen.sv
module mem_req_gen #(
  parameter int XW  = 16,
  parameter int YW  = 16,
  parameter int IDW = 4,
  parameter int CW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_valid,
  input  logic [2:0]     acc_kind,
  input  logic [XW-1:0]  pc,
  input  logic [XW-1:0]  op_idx,
  input  logic [XW-1:0]  in_x,
  input  logic [YW-1:0]  in_y,
  input  logic [IDW-1:0] in_id,
  input  logic [IDW-1:0] out_id,
  input  logic [XW-1:0]  work_i,
  input  logic [YW-1:0]  work_j,
  input  logic [CW-1:0]  work_cond,
  input  logic [CW-1:0]  imm_cond,
  input  logic           cond_sel,
  input  logic           cond_en,
  output logic           acc_ready,
  output logic           req_valid,
  output logic [2:0]     req_type,
  output logic [XW-1:0]  req_x,
  output logic [YW-1:0]  req_y,
  output logic [IDW-1:0] req_id,
  output logic           test_req_valid,
  output logic [CW-1:0]  test_val,
  output logic [XW-1:0]  test_i,
  output logic [YW-1:0]  test_j,
  input  logic           test_done,
  input  logic           test_pass,
  output logic           discard
);
  localparam logic [2:0] K_INSTR = 3'd0;
  localparam logic [2:0] K_FCON  = 3'd1;
  localparam logic [2:0] K_ICON  = 3'd2;
  localparam logic [2:0] K_BCON  = 3'd3;
  localparam logic [2:0] K_IN    = 3'd4;
  localparam logic [2:0] K_OUT   = 3'd5;

  logic           pending;
  logic [XW-1:0]  lat_i;
  logic [YW-1:0]  lat_j;
  logic [IDW-1:0] lat_id;
  logic [CW-1:0]  lat_cond;

  wire accept  = acc_valid && !pending;
  wire legal   = acc_kind <= K_OUT;
  wire gate    = accept && acc_kind == K_OUT && cond_en;
  wire resolve = pending && test_done;

  assign acc_ready      = !pending;
  assign test_req_valid = pending;
  assign test_val       = lat_cond;
  assign test_i         = lat_i;
  assign test_j         = lat_j;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      req_valid <= 1'b0;
      discard   <= 1'b0;
      req_type  <= K_INSTR;
      req_x     <= '0;
      req_y     <= '0;
      req_id    <= '0;
      lat_i     <= '0;
      lat_j     <= '0;
      lat_id    <= '0;
      lat_cond  <= '0;
    end else begin
      req_valid <= 1'b0;
      discard   <= 1'b0;
      if (resolve) begin
        pending <= 1'b0;
        if (test_pass) begin
          req_valid <= 1'b1;
          req_type  <= K_OUT;
          req_x     <= lat_i;
          req_y     <= lat_j;
          req_id    <= lat_id;
        end else begin
          discard <= 1'b1;
        end
      end else if (gate) begin
        pending  <= 1'b1;
        lat_i    <= work_i;
        lat_j    <= work_j;
        lat_id   <= out_id;
        lat_cond <= cond_sel ? imm_cond : work_cond;
      end else if (accept && legal) begin
        req_valid <= 1'b1;
        req_type  <= acc_kind;
        case (acc_kind)
          K_INSTR: begin req_x <= pc;     req_y <= '0;     req_id <= '0;     end
          K_FCON, K_ICON, K_BCON:
                   begin req_x <= op_idx; req_y <= '0;     req_id <= '0;     end
          K_IN:    begin req_x <= in_x;   req_y <= in_y;   req_id <= in_id;  end
          default: begin req_x <= work_i; req_y <= work_j; req_id <= out_id; end
        endcase
      end
    end
  end

  assert_type_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_type <= K_OUT);
  assert_const_y_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type <= K_BCON) |-> req_y == '0);
  assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req_valid && test_done && test_pass) |=> (req_valid && req_type == K_OUT && !discard));
  assert_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req_valid && test_done && !test_pass) |=> (discard && !req_valid));
  assert_discard_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> !discard);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req_valid && !test_done) |=> (test_req_valid && !req_valid && $stable(test_i) && $stable(test_j) && $stable(test_val)));
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && acc_valid && acc_kind == K_OUT && cond_en) |=> (!req_valid && !acc_ready));
  assert_nocond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && acc_valid && acc_kind == K_OUT && !cond_en) |=> (req_valid && !test_req_valid && req_x == $past(work_i)));
endmodule

// File: tb/mem_req_gen_bench.sv
module mem_req_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XW = 16, YW = 16, IDW = 4, CW = 32;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0; logic [2:0] acc_kind = 0;
  logic [XW-1:0] pc = 0, op_idx = 0, in_x = 0, work_i = 0;
  logic [YW-1:0] in_y = 0, work_j = 0;
  logic [IDW-1:0] in_id = 0, out_id = 0;
  logic [CW-1:0] work_cond = 0, imm_cond = 0;
  logic cond_sel = 0, cond_en = 0, test_done = 0, test_pass = 0;
  logic acc_ready, req_valid, test_req_valid, discard;
  logic [2:0] req_type;
  logic [XW-1:0] req_x, test_i;
  logic [YW-1:0] req_y, test_j;
  logic [IDW-1:0] req_id;
  logic [CW-1:0] test_val;
  int checks = 0, failures = 0;
  bit finished = 0;

  mem_req_gen #(.XW(XW), .YW(YW), .IDW(IDW), .CW(CW)) u_mem_req_gen (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind), .pc(pc),
    .op_idx(op_idx), .in_x(in_x), .in_y(in_y), .in_id(in_id), .out_id(out_id),
    .work_i(work_i), .work_j(work_j), .work_cond(work_cond), .imm_cond(imm_cond),
    .cond_sel(cond_sel), .cond_en(cond_en), .acc_ready(acc_ready), .req_valid(req_valid),
    .req_type(req_type), .req_x(req_x), .req_y(req_y), .req_id(req_id),
    .test_req_valid(test_req_valid), .test_val(test_val), .test_i(test_i), .test_j(test_j),
    .test_done(test_done), .test_pass(test_pass), .discard(discard));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [XW-1:0] exp_x(input logic [2:0] k);
    case (k)
      3'd0: return pc;
      3'd1, 3'd2, 3'd3: return op_idx;
      3'd4: return in_x;
      default: return work_i;
    endcase
  endfunction
  function automatic logic [YW-1:0] exp_y(input logic [2:0] k);
    return (k == 3'd4) ? in_y : (k == 3'd5) ? work_j : '0;
  endfunction
  function automatic logic [IDW-1:0] exp_id(input logic [2:0] k);
    return (k == 3'd4) ? in_id : (k == 3'd5) ? out_id : '0;
  endfunction
  function automatic bit test_fn(input logic [CW-1:0] v, input logic [XW-1:0] i, input logic [YW-1:0] j);
    return ^{v, i, j};
  endfunction

  task automatic randomize_ops();
    pc = XW'($urandom); op_idx = XW'($urandom); in_x = XW'($urandom);
    in_y = YW'($urandom); in_id = IDW'($urandom); out_id = IDW'($urandom);
    work_i = XW'($urandom); work_j = YW'($urandom);
    work_cond = $urandom; imm_cond = $urandom;
    cond_sel = 1'($urandom);
  endtask

  task automatic run_access(input logic [2:0] k, input bit en, input int lat, input bit stray, input int force_pass);
    logic [XW-1:0] ex, si; logic [YW-1:0] ey, sj; logic [IDW-1:0] eid;
    logic [CW-1:0] ev; bit p;
    @(negedge clk);
    acc_kind = k; cond_en = en; acc_valid = 1;
    ex = exp_x(k); ey = exp_y(k); eid = exp_id(k);
    ev = cond_sel ? imm_cond : work_cond;
    si = work_i; sj = work_j;
    @(posedge clk); #1;
    if (k == 3'd5 && en) begin
      check(!req_valid, "R6 no immediate write", req_valid, 0);
      check(test_req_valid && !acc_ready, "R6 pending", {test_req_valid, acc_ready}, 2'b10);
      check(test_i == si && test_j == sj, "R6 test pair", {test_i, test_j}, {si, sj});
      check(test_val == ev, "R7 test value", test_val, ev);
      for (int c = 0; c < lat; c++) begin
        @(negedge clk);
        acc_valid = stray;
        if (stray) begin acc_kind = 3'($urandom_range(0, 5)); randomize_ops(); end
        @(posedge clk); #1;
        check(!req_valid && test_req_valid, "R11 stray ignored", req_valid, 0);
        check(test_i == si && test_j == sj && test_val == ev, "R11 fields held", {test_i, test_j}, {si, sj});
      end
      @(negedge clk);
      acc_valid = 0;
      p = (force_pass < 0) ? test_fn(test_val, test_i, test_j) : force_pass[0];
      test_done = 1; test_pass = p;
      @(posedge clk); #1;
      if (p) begin
        check(req_valid && !discard, "R8 released write", {req_valid, discard}, 2'b10);
        check(req_type == 3'd5 && req_x == si && req_y == sj && req_id == eid,
              "R8 write fields", {req_type, req_x, req_y}, {3'd5, si, sj});
      end else begin
        check(!req_valid && discard, "R9 dropped write", {req_valid, discard}, 2'b01);
      end
      @(negedge clk); test_done = 0; test_pass = 0;
      @(posedge clk); #1;
      check(!req_valid && !discard && acc_ready && !test_req_valid, "R9 R12 single pulse",
            {req_valid, discard, acc_ready}, 3'b001);
    end else begin
      if (k <= 3'd5) begin
        string tg;
        tg = (k == 0) ? "R2 fetch" : (k <= 3) ? "R3 const" : (k == 4) ? "R4 input" : "R5 ungated write";
        check(req_valid && !test_req_valid, tg, {req_valid, test_req_valid}, 2'b10);
        check(req_type == k && req_x == ex && req_y == ey && req_id == eid, tg,
              {req_type, req_x, req_y, req_id}, {k, ex, ey, eid});
      end else begin
        check(!req_valid && !test_req_valid, "R10 illegal kind", {req_valid, test_req_valid}, 0);
      end
      @(negedge clk); acc_valid = 0;
      @(posedge clk); #1;
      check(!req_valid, "R12 one-cycle request", req_valid, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(!req_valid && !discard && !test_req_valid && acc_ready, "R1 reset state",
          {req_valid, discard, test_req_valid, acc_ready}, 4'b0001);
    @(negedge clk); rst_n = 1;
    pc = '1; op_idx = 16'h8001; in_x = 16'h1234; in_y = 16'hfedc; in_id = 4'hf;
    out_id = 4'ha; work_i = 16'h00ff; work_j = 16'hff00; work_cond = 32'h1; imm_cond = 32'h2;
    for (int k = 0; k < 8; k++) run_access(3'(k), 1'b0, 0, 1'b0, -1);
    cond_sel = 1; run_access(3'd5, 1'b1, 0, 1'b0, 1);
    cond_sel = 0; run_access(3'd5, 1'b1, 2, 1'b1, 0);
    cond_sel = 1; run_access(3'd5, 1'b1, 3, 1'b1, 0);
    run_access(3'd6, 1'b1, 0, 1'b0, -1);
    run_access(3'd7, 1'b1, 0, 1'b0, -1);
    for (int n = 0; n < 400; n++) begin
      randomize_ops();
      run_access(3'($urandom_range(0, 7)), 1'($urandom), $urandom_range(0, 4), 1'($urandom), -1);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule